// File: doc/BRIEF.md
# Four-Channel PWM Controller

A pulse-width modulation peripheral with four independent channels, reached through a single-cycle 32-bit memory-mapped register bus. Each channel divides the input clock by a power of two, runs a 16-bit up-counter over a programmable period, and drives its output to a selected active level while the counter is below the duty value. The inactive level is the opposite of the active level.

While a channel runs, its active duty and period never change in the middle of a period. New values are written to update registers and are taken over at the next period boundary. A disable request also waits for the boundary. A clear-on-read status word records which channels have completed a period since it was last read. Software uses the running mask to see when a disable has actually taken hold.

Top module: `pwm_ctrl`

## Requirements
- R1: After reset every channel is stopped, every register reads zero, and every output sits at its inactive level (logic 1, because the polarity bit resets to 0).
- R2: Register map: enable mask at 0x004 and disable mask at 0x008 (write-one, bit n = channel n, both read zero), running mask at 0x00C, end-of-period flags at 0x01C. Channel n occupies 0x200 + n*0x20: mode at +0x00 (bits 3:0 prescale, bit 9 polarity), duty at +0x04, duty update at +0x08, period at +0x0C, period update at +0x10. Only the low 16 bits of duty and period are kept. Unmapped offsets and unused bits read zero.
- R3: A running channel advances its counter once per 2^prescale input clocks, counting 0 to period-1 and then wrapping. The output equals mode bit 9 while the counter is below the active duty, and the inverse otherwise. k cycles after the enabling write, the counter holds floor(k / 2^prescale) mod period.
- R4: Prescale values 11 to 15 freeze the counter, so no period boundary occurs.
- R5: Writes to the duty and period registers load the active values directly while the channel is stopped, and are ignored while it runs.
- R6: A write to a duty or period update register is copied into the active value at the first period boundary after the write.
- R7: A channel's end-of-period flag is set at each period boundary. A read of 0x01C returns the flags and clears them, except that a boundary in the same cycle as the read leaves its flag set.
- R8: Enabling a stopped channel starts it with the counter at 0. Enabling a running channel does not restart it, but cancels any pending disable.
- R9: Disabling a running channel lets the current period finish. The running bit stays set until that boundary, and then the output returns to the inactive level.
- R10: A period value of 0 behaves like a period of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| pwm_o | output | 4 | Channel outputs, bit n = channel n |

## Verification
The bench builds the block with its default parameters: four channels, 16-bit counters and a prescale limit of 10. It sweeps prescale 0 to 2, period 0 to 5, duty 0 to 6 and both polarities, rotating over all four channels. This reaches every relation between duty and period: zero duty, duty at or above the period, and the degenerate periods 0 and 1. Directed cycle-exact runs then cover the boundary-timed behaviour: update-register hand-over, ignored writes, cancelled and deferred disables, a flag set in the same cycle as its clearing read, and a frozen prescaler.

// File: rtl/pwm_ctrl_pkg.sv
`timescale 1ns/1ps
package pwm_ctrl_pkg;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned CH_SH   = 5;
  localparam int unsigned PRESC_W = 4;
  localparam int unsigned POL_BIT = 9;

  localparam logic [ADDR_W-1:0] OFS_ENA  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_DIS  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_RUN  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_FLAG = 12'h01C;
  localparam logic [ADDR_W-1:0] CH_BASE  = 12'h200;

  localparam logic [CH_SH-1:0] REG_MODE     = 5'h00;
  localparam logic [CH_SH-1:0] REG_DUTY     = 5'h04;
  localparam logic [CH_SH-1:0] REG_DUTY_UPD = 5'h08;
  localparam logic [CH_SH-1:0] REG_PER      = 5'h0C;
  localparam logic [CH_SH-1:0] REG_PER_UPD  = 5'h10;

  typedef struct packed {
    logic               pol;
    logic [PRESC_W-1:0] presc;
  } mode_t;
endpackage

// File: rtl/pwm_ctrl_presc.sv
`timescale 1ns/1ps
module pwm_ctrl_presc #(
  parameter int unsigned PRESC_W   = 4,
  parameter int unsigned PRESC_MAX = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [PRESC_W-1:0] sel_i,
  output logic               tick_o
);
  logic [PRESC_MAX-1:0] div_q, mask;

  always_comb begin
    for (int i = 0; i < PRESC_MAX; i++) mask[i] = (PRESC_W'(i) < sel_i);
  end

  // divider restarts from zero whenever the channel is stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (!run_i) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  assign tick_o = run_i && (sel_i <= PRESC_W'(PRESC_MAX)) && ((div_q & mask) == mask);
endmodule

// File: rtl/pwm_ctrl_chan.sv
`timescale 1ns/1ps
module pwm_ctrl_chan #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_set_i,
  input  logic             dis_req_i,
  input  logic             pol_i,
  input  logic             wr_duty_i,
  input  logic             wr_duty_upd_i,
  input  logic             wr_per_i,
  input  logic             wr_per_upd_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic             run_o,
  output logic             wrap_o,
  output logic [CNT_W-1:0] duty_o,
  output logic [CNT_W-1:0] duty_buf_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] per_buf_o,
  output logic             pwm_o
);
  logic             run_q, stop_q, duty_pend_q, per_pend_q;
  logic [CNT_W-1:0] cnt_q, duty_q, per_q, duty_buf_q, per_buf_q;
  logic [CNT_W:0]   cnt_nxt;
  logic             wrap;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
  // period 0 compares like period 1
  assign wrap    = run_q && tick_i && (cnt_nxt >= {1'b0, per_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      stop_q      <= 1'b0;
      cnt_q       <= '0;
      duty_q      <= '0;
      per_q       <= '0;
      duty_buf_q  <= '0;
      per_buf_q   <= '0;
      duty_pend_q <= 1'b0;
      per_pend_q  <= 1'b0;
    end else begin
      if (wr_duty_upd_i) begin
        duty_buf_q  <= wdata_i;
        duty_pend_q <= 1'b1;
      end else if (wrap) begin
        duty_pend_q <= 1'b0;
      end
      if (wr_per_upd_i) begin
        per_buf_q  <= wdata_i;
        per_pend_q <= 1'b1;
      end else if (wrap) begin
        per_pend_q <= 1'b0;
      end

      if (wrap && duty_pend_q)     duty_q <= duty_buf_q;
      else if (!run_q && wr_duty_i) duty_q <= wdata_i;
      if (wrap && per_pend_q)      per_q <= per_buf_q;
      else if (!run_q && wr_per_i) per_q <= wdata_i;

      if (run_q) begin
        if (tick_i) cnt_q <= wrap ? '0 : cnt_nxt[CNT_W-1:0];
        if (wrap && stop_q) begin
          run_q  <= 1'b0;
          stop_q <= 1'b0;
        end else if (en_set_i) begin
          stop_q <= 1'b0;
        end else if (dis_req_i) begin
          stop_q <= 1'b1;
        end
      end else if (en_set_i) begin
        run_q  <= 1'b1;
        stop_q <= 1'b0;
        cnt_q  <= '0;
      end
    end
  end

  assign run_o      = run_q;
  assign wrap_o     = wrap;
  assign duty_o     = duty_q;
  assign duty_buf_o = duty_buf_q;
  assign per_o      = per_q;
  assign per_buf_o  = per_buf_q;
  assign pwm_o      = (run_q && (cnt_q < duty_q)) ? pol_i : ~pol_i;
endmodule

// File: rtl/pwm_ctrl.sv
`timescale 1ns/1ps
module pwm_ctrl
  import pwm_ctrl_pkg::*;
#(
  parameter int unsigned NCH       = 4,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PRESC_MAX = 10,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [NCH-1:0]    pwm_o
);
  localparam int unsigned CH_IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned HI_W     = ADDR_W - CH_SH;

  logic                            wr, rd, rd_flag, in_ch;
  logic [ADDR_W-1:0]               rel;
  logic [CH_IDX_W-1:0]             ch_sel;
  logic [CH_SH-1:0]                reg_sel;
  logic [NCH-1:0]                  run_v, wrap_v, ena_v, dis_v, pol_v, flag_q;
  logic [NCH-1:0][PRESC_W-1:0]     presc_v;
  logic [NCH-1:0][CNT_W-1:0]       duty_v, dbuf_v, per_v, pbuf_v;

  assign wr      = bus_req_i && bus_we_i;
  assign rd      = bus_req_i && !bus_we_i;
  assign rd_flag = rd && (bus_addr_i == OFS_FLAG);
  assign rel     = bus_addr_i - CH_BASE;
  assign in_ch   = (bus_addr_i >= CH_BASE) && (rel[ADDR_W-1:CH_SH] < HI_W'(NCH));
  assign ch_sel  = rel[CH_SH +: CH_IDX_W];
  assign reg_sel = rel[CH_SH-1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    mode_t mode_q;
    logic  hit, tick;

    assign hit      = wr && in_ch && (ch_sel == CH_IDX_W'(g));
    assign ena_v[g] = wr && (bus_addr_i == OFS_ENA) && bus_wdata_i[g];
    assign dis_v[g] = wr && (bus_addr_i == OFS_DIS) && bus_wdata_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mode_q <= '0;
      else if (hit && reg_sel == REG_MODE)
        mode_q <= '{pol: bus_wdata_i[POL_BIT], presc: bus_wdata_i[PRESC_W-1:0]};
    end

    assign pol_v[g]   = mode_q.pol;
    assign presc_v[g] = mode_q.presc;

    pwm_ctrl_presc #(.PRESC_W(PRESC_W), .PRESC_MAX(PRESC_MAX)) i_presc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (run_v[g]),
      .sel_i (mode_q.presc),
      .tick_o(tick)
    );

    pwm_ctrl_chan #(.CNT_W(CNT_W)) i_chan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .tick_i       (tick),
      .en_set_i     (ena_v[g]),
      .dis_req_i    (dis_v[g]),
      .pol_i        (mode_q.pol),
      .wr_duty_i    (hit && reg_sel == REG_DUTY),
      .wr_duty_upd_i(hit && reg_sel == REG_DUTY_UPD),
      .wr_per_i     (hit && reg_sel == REG_PER),
      .wr_per_upd_i (hit && reg_sel == REG_PER_UPD),
      .wdata_i      (bus_wdata_i[CNT_W-1:0]),
      .run_o        (run_v[g]),
      .wrap_o       (wrap_v[g]),
      .duty_o       (duty_v[g]),
      .duty_buf_o   (dbuf_v[g]),
      .per_o        (per_v[g]),
      .per_buf_o    (pbuf_v[g]),
      .pwm_o        (pwm_o[g])
    );
  end

  // boundary in the same cycle as a clearing read keeps its flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (rd_flag ? '0 : flag_q) | wrap_v;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      if (bus_addr_i == OFS_RUN)       bus_rdata_o[NCH-1:0] = run_v;
      else if (bus_addr_i == OFS_FLAG) bus_rdata_o[NCH-1:0] = flag_q;
      else if (in_ch) begin
        case (reg_sel)
          REG_MODE: begin
            bus_rdata_o[POL_BIT]       = pol_v[ch_sel];
            bus_rdata_o[PRESC_W-1:0]   = presc_v[ch_sel];
          end
          REG_DUTY:     bus_rdata_o[CNT_W-1:0] = duty_v[ch_sel];
          REG_DUTY_UPD: bus_rdata_o[CNT_W-1:0] = dbuf_v[ch_sel];
          REG_PER:      bus_rdata_o[CNT_W-1:0] = per_v[ch_sel];
          REG_PER_UPD:  bus_rdata_o[CNT_W-1:0] = pbuf_v[ch_sel];
          default:      bus_rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_ctrl_chk.sv
`timescale 1ns/1ps
module pwm_ctrl_chk
  import pwm_ctrl_pkg::*;
#(
  parameter int unsigned NCH       = 4,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PRESC_MAX = 10
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NCH-1:0]              run_v,
  input logic [NCH-1:0]              wrap_v,
  input logic [NCH-1:0]              ena_v,
  input logic [NCH-1:0]              flag_q,
  input logic                        rd_flag,
  input logic [NCH-1:0][CNT_W-1:0]   duty_v,
  input logic [NCH-1:0][CNT_W-1:0]   per_v,
  input logic [NCH-1:0][PRESC_W-1:0] presc_v
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_v[i] |=> flag_q[i]);
    p_flag_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_flag && !wrap_v[i]) |=> !flag_q[i]);
    p_stop_on_boundary_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_v[i] && !wrap_v[i]) |=> run_v[i]);
    p_stopped_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_v[i] && !ena_v[i]) |=> !run_v[i]);
    p_duty_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_v[i] && !wrap_v[i]) |=> $stable(duty_v[i]));
    p_per_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_v[i] && !wrap_v[i]) |=> $stable(per_v[i]));
    p_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_v[i] && presc_v[i] > PRESC_W'(PRESC_MAX)) |-> !wrap_v[i]);
  end
endmodule

bind pwm_ctrl pwm_ctrl_chk #(.NCH(NCH), .CNT_W(CNT_W), .PRESC_MAX(PRESC_MAX)) i_pwm_ctrl_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .run_v  (run_v),
  .wrap_v (wrap_v),
  .ena_v  (ena_v),
  .flag_q (flag_q),
  .rd_flag(rd_flag),
  .duty_v (duty_v),
  .per_v  (per_v),
  .presc_v(presc_v)
);

// File: tb/test_pwm_ctrl.sv
`timescale 1ns/1ps
module test_pwm_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm;
  logic [3:0]  pol_m = 4'h0;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 0;

  localparam logic [11:0] A_ENA = 12'h004, A_DIS = 12'h008, A_RUN = 12'h00C, A_FLAG = 12'h01C;

  always #2.5 clk = ~clk;

  pwm_ctrl i_pwm_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pwm_o(pwm)
  );

  function automatic logic [11:0] chreg(input int ch, input int ofs);
    return 12'(32'h200 + ch * 32 + ofs);
  endfunction

  task automatic chk(input string req_s, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req_s, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk);
    #1 req = 1'b0;
  endtask

  task automatic stop_chan(input int ch);
    logic [31:0] r;
    bit          gone = 0;
    bus_wr(A_DIS, 32'(1) << ch);
    for (int i = 0; i < 400 && !gone; i++) begin
      bus_rd(A_RUN, r);
      if (!r[ch]) gone = 1;
    end
    chk("R9 channel reaches stop", {31'd0, gone}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [3:0]  ev;
    logic        e;
    int          ch, pe, n, idx;
    idx = 0;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 outputs inactive", {28'd0, pwm}, 32'hF);
    bus_rd(A_RUN, r);              chk("R1 running mask", r, 0);
    bus_rd(A_FLAG, r);             chk("R1 flags", r, 0);
    bus_rd(chreg(1, 0), r);        chk("R1 mode", r, 0);
    bus_rd(chreg(3, 4'hC), r);     chk("R1 period", r, 0);

    // R2 map, field masking, unmapped
    bus_wr(chreg(2, 0), 32'hFFFF_FFFF);
    bus_rd(chreg(2, 0), r);        chk("R2 mode fields", r, 32'h0000_020F);
    bus_wr(chreg(2, 0), 32'h0);
    bus_wr(chreg(2, 4), 32'h0001_2345);
    bus_rd(chreg(2, 4), r);        chk("R2 duty 16-bit", r, 32'h2345);
    bus_wr(chreg(0, 4'hC), 32'hFFFF_FFFF);
    bus_rd(chreg(0, 4'hC), r);     chk("R2 period max", r, 32'hFFFF);
    bus_rd(12'h100, r);            chk("R2 unmapped 0x100", r, 0);
    bus_rd(12'h280, r);            chk("R2 beyond last channel", r, 0);
    bus_rd(chreg(0, 5'h14), r);    chk("R2 unused channel slot", r, 0);
    bus_rd(A_ENA, r);              chk("R2 enable reads zero", r, 0);

    // R3 R5 R10 sweep
    for (int p = 0; p < 3; p++)
      for (int per = 0; per < 6; per++)
        for (int d = 0; d < 7; d++)
          for (int pl = 0; pl < 2; pl++) begin
            ch = idx % 4; idx++;
            bus_wr(chreg(ch, 0), (32'(pl) << 9) | 32'(p));
            pol_m[ch] = pl[0];
            bus_wr(chreg(ch, 4'hC), 32'(per));
            bus_wr(chreg(ch, 4), 32'(d));
            bus_wr(A_ENA, 32'(1) << ch);
            pe = (per == 0) ? 1 : per;
            n  = (pe << p) * 2 + 2;
            for (int k = 0; k < n; k++) begin
              @(negedge clk);
              e = (((k >> p) % pe) < d) ? pl[0] : ~pl[0];
              ev = ~pol_m; ev[ch] = e;
              chk("R3 R10 waveform", {28'd0, pwm}, {28'd0, ev});
            end
            stop_chan(ch);
          end

    // R5 R6 buffered updates on channel 2
    bus_wr(chreg(2, 0), 32'h200); pol_m[2] = 1'b1;
    bus_wr(chreg(2, 4'hC), 4);
    bus_wr(chreg(2, 4), 1);
    bus_wr(A_ENA, 32'h4);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      req = 1'b0; we = 1'b0;
      if (k < 4)       e = (k < 1);
      else if (k < 10) e = (k - 4 < 3);
      else             e = (k - 10 < 3);
      ev = ~pol_m; ev[2] = e;
      chk("R6 update at boundary", {28'd0, pwm}, {28'd0, ev});
      case (k)
        1: begin req = 1; we = 1; addr = chreg(2, 8);    wdata = 3; end
        2: begin req = 1; we = 1; addr = chreg(2, 5'h10); wdata = 6; end
        5: begin req = 1; we = 1; addr = chreg(2, 4);    wdata = 0; end
        default: ;
      endcase
    end
    bus_rd(chreg(2, 4), r);    chk("R5 duty write ignored while running", r, 3);
    bus_rd(chreg(2, 4'hC), r); chk("R6 period taken from update", r, 6);
    stop_chan(2);

    // R8 R9 enable/disable ordering on channel 1
    bus_wr(chreg(1, 0), 32'h200); pol_m[1] = 1'b1;
    bus_wr(chreg(1, 4'hC), 4);
    bus_wr(chreg(1, 4), 2);
    bus_wr(A_ENA, 32'h2);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      req = 1'b0; we = 1'b0;
      ev = ~pol_m; ev[1] = (k < 8) ? ((k % 4) < 2) : 1'b0;
      chk("R8 R9 output", {28'd0, pwm}, {28'd0, ev});
      case (k)
        0: begin req = 1; we = 1; addr = A_ENA; wdata = 2; end
        1: begin req = 1; we = 1; addr = A_DIS; wdata = 2; end
        2: begin req = 1; we = 1; addr = A_ENA; wdata = 2; end
        5: begin req = 1; we = 1; addr = A_DIS; wdata = 2; end
        default: begin
          req = 1; we = 0; addr = A_RUN;
          #1 chk("R9 running bit held to boundary", {31'd0, rdata[1]}, {31'd0, (k < 8)});
        end
      endcase
    end
    bus_rd(A_FLAG, r); chk("R7 flag after periods", {31'd0, r[1]}, 1);
    bus_rd(A_FLAG, r); chk("R7 clear on read", r, 0);

    // R7 set wins over clearing read, channel 3
    bus_wr(chreg(3, 0), 32'h0); pol_m[3] = 1'b0;
    bus_wr(chreg(3, 4'hC), 2);
    bus_wr(chreg(3, 4), 1);
    bus_rd(A_FLAG, r);
    bus_wr(A_ENA, 32'h8);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      req = 1'b0;
      if (k >= 1) begin
        req = 1; we = 0; addr = A_FLAG;
        #1 chk("R7 flag vs read collision", {31'd0, rdata[3]}, {31'd0, (k == 2 || k == 4)});
      end
    end
    stop_chan(3);

    // R4 frozen prescaler, channel 0
    bus_wr(chreg(0, 0), 32'h20C); pol_m[0] = 1'b1;
    bus_wr(chreg(0, 4'hC), 3);
    bus_wr(chreg(0, 4), 1);
    bus_rd(A_FLAG, r);
    bus_wr(A_ENA, 32'h1);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk("R4 counter frozen", {31'd0, pwm[0]}, 1);
    end
    bus_rd(A_FLAG, r); chk("R4 no boundary", {31'd0, r[0]}, 0);
    bus_wr(A_DIS, 32'h1);
    repeat (8) @(negedge clk);
    bus_rd(A_RUN, r);  chk("R9 disable waits for boundary", {31'd0, r[0]}, 1);
    bus_wr(chreg(0, 0), 32'h200);
    for (int i = 0; i < 10; i++) bus_rd(A_RUN, r);
    chk("R9 stop after prescaler release", {31'd0, r[0]}, 0);
    @(negedge clk);
    chk("R9 inactive after stop", {31'd0, pwm[0]}, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule